// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned N-bit operands by repeated subtraction. Two working registers hold the operands. Each step compares them with a ripple chain of one-bit magnitude cells. One conditional subtractor then forms the larger value minus the smaller, and the result is written back over the larger register. The smaller register keeps its value. The step repeats on every clock cycle. When either register reaches zero, the value of the other register is the result.

Raising `load_i` captures `x_i` and `y_i`. The search begins on the first clock edge at which `load_i` is low. When the search ends, `z_o` carries the divisor and `done_o` rises. Both stay unchanged until `load_i` is raised again. Each subtraction strictly lowers the sum of the two registers, so the number of steps is bounded by the operand values.

Top module: `gcd_euclid`

## Requirements
- R1: A synchronous active-high reset clears both working registers and `z_o` to 0 and holds `done_o` low.
- R2: On every clock edge with `load_i` high, the registers take `x_i` and `y_i`, `done_o` is low after that edge, and no subtraction takes place.
- R3: The comparator chain starts at the most significant bit with no decision. It yields the pair (greater, less) = (1,0) when the first register is greater, (0,1) when it is less, and (0,0) when the two are equal. A cell that receives a decision passes it on unchanged.
- R4: On each edge with `load_i` low, `done_o` low and both registers nonzero, exactly one register changes. The larger register, or the first register on a tie, becomes the difference, and the other register keeps its value.
- R5: On the first edge with `load_i` low at which either register is zero, `done_o` rises and `z_o` takes the value of the nonzero register.
- R6: If an input is zero at load, `done_o` is high after the first edge following the fall of `load_i`, and `z_o` equals the other input. If both inputs are zero, `z_o` is 0.
- R7: Equal nonzero inputs finish after exactly two edges following the fall of `load_i`, and `z_o` equals the common value.
- R8: While `load_i` stays low, `done_o` stays high and `z_o` stays stable once set. Raising `load_i` clears `done_o` on the next edge.
- R9: Whenever `done_o` is high, `z_o` equals the GCD of the last loaded operands. The number of edges from the fall of `load_i` to `done_o` is the number of subtractions plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | High: capture operands; low: iterate |
| x_i | input | N | First operand |
| y_i | input | N | Second operand |
| z_o | output | N | GCD result, valid while `done_o` is high |
| done_o | output | 1 | Result ready |

## Verification
Termination and a new load can fall on the same clock edge. At that edge the registers meet the end condition and `load_i` is high again. The bench provokes this by loading equal operands, letting one subtraction happen, and then raising `load_i` with fresh operands just before the edge at which `done_o` would rise. Load must win: `done_o` stays low and the new pair runs to its own correct divisor with the predicted latency.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  // Decision pair carried along the comparator chain.
  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_pair_t;

  localparam cmp_pair_t CMP_UNDECIDED = '{gt: 1'b0, lt: 1'b0};
endpackage

// File: rtl/gcd_cmp_cell.sv
module gcd_cmp_cell
  import gcd_pkg::*;
(
  input  logic      a_bit,
  input  logic      b_bit,
  input  cmp_pair_t dec_in,
  output cmp_pair_t dec_out
);
  logic open_q;
  assign open_q      = ~dec_in.gt & ~dec_in.lt;
  assign dec_out.gt  = dec_in.gt | (open_q & a_bit & ~b_bit);
  assign dec_out.lt  = dec_in.lt | (open_q & ~a_bit & b_bit);
endmodule

// File: rtl/gcd_cmp_chain.sv
module gcd_cmp_chain
  import gcd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic         a_gt,
  output logic         a_lt
);
  cmp_pair_t link [N+1];

  // link[N] enters at the MSB; link[0] leaves after the LSB.
  assign link[N] = CMP_UNDECIDED;

  for (genvar i = N - 1; i >= 0; i--) begin : g_cell
    gcd_cmp_cell u_cell (
      .a_bit  (a[i]),
      .b_bit  (b[i]),
      .dec_in (link[i+1]),
      .dec_out(link[i])
    );
  end

  assign a_gt = link[0].gt;
  assign a_lt = link[0].lt;
endmodule

// File: rtl/gcd_csub.sv
module gcd_csub #(
  parameter int N = 8
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         swap,   // 1: op_b - op_a, 0: op_a - op_b
  output logic [N-1:0] diff
);
  logic [N-1:0] minu, subt;
  logic [N:0]   carry;

  assign minu     = swap ? op_b : op_a;
  assign subt     = swap ? op_a : op_b;
  assign carry[0] = 1'b1;  // +1 of the two's complement

  for (genvar i = 0; i < N; i++) begin : g_fa
    logic p, q;
    assign p          = minu[i];
    assign q          = ~subt[i];
    assign diff[i]    = p ^ q ^ carry[i];
    assign carry[i+1] = (p & q) | (carry[i] & (p ^ q));
  end
endmodule

// File: rtl/gcd_euclid.sv
module gcd_euclid #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  output logic [N-1:0] z_o,
  output logic         done_o
);
  localparam logic [N-1:0] ZERO = '0;

  logic [N-1:0] ra_q, rb_q, z_q, diff;
  logic         done_q, a_gt, a_lt, any_zero;

  gcd_cmp_chain #(.N(N)) u_cmp (
    .a   (ra_q),
    .b   (rb_q),
    .a_gt(a_gt),
    .a_lt(a_lt)
  );

  gcd_csub #(.N(N)) u_sub (
    .op_a(ra_q),
    .op_b(rb_q),
    .swap(a_lt),
    .diff(diff)
  );

  assign any_zero = (ra_q == ZERO) || (rb_q == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q   <= ZERO;
      rb_q   <= ZERO;
      z_q    <= ZERO;
      done_q <= 1'b0;
    end else if (load_i) begin
      ra_q   <= x_i;
      rb_q   <= y_i;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (any_zero) begin
        done_q <= 1'b1;
        z_q    <= ra_q | rb_q;
      end else if (a_lt) begin
        rb_q <= diff;
      end else begin
        ra_q <= diff;
      end
    end
  end

  assign z_o    = z_q;
  assign done_o = done_q;

  // R2: load captures the operands and clears done
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (ra_q == $past(x_i)) && (rb_q == $past(y_i)) && !done_q);

  // R3: the chain's decision agrees with the register magnitudes
  a_r3_cmp_code: assert property (@(posedge clk) disable iff (rst)
    (a_gt == (ra_q > rb_q)) && (a_lt == (ra_q < rb_q)));

  // R4: a step changes exactly one register
  a_r4_one_reg: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !done_q && !any_zero) |=>
      ((ra_q == $past(ra_q)) != (rb_q == $past(rb_q))));

  // R4: a step strictly lowers the register sum
  a_r4_shrinks: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !done_q && !any_zero) |=>
      ({1'b0, ra_q} + {1'b0, rb_q}) < ({1'b0, $past(ra_q)} + {1'b0, $past(rb_q)}));

  // R5: done only with a zero register
  a_r5_done_zero: assert property (@(posedge clk) disable iff (rst)
    done_q |-> any_zero);

  // R5: an idle zero register raises done on the next edge
  a_r5_stop: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !done_q && any_zero) |=> done_q);

  // R8: result holds until a new load
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (done_q && !load_i) |=> done_q && $stable(z_q));

  // R9: result is the surviving register
  a_r9_result: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (z_q == (ra_q | rb_q)));
endmodule

// File: tb/sim_gcd_euclid.sv
`timescale 1ns/1ps
module sim_gcd_euclid;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [N-1:0] x_i = '0, y_i = '0;
  logic [N-1:0] z_o;
  logic         done_o;

  int checks = 0;
  int fails  = 0;
  bit hung   = 0;

  always #2.5 clk = ~clk;

  gcd_euclid #(.N(N)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i),
    .x_i(x_i), .y_i(y_i), .z_o(z_o), .done_o(done_o)
  );

  function automatic int ref_gcd(input int a, input int b);
    while (a != 0 && b != 0) begin
      if (a < b) b = b - a; else a = a - b;
    end
    return a + b;
  endfunction

  function automatic int ref_steps(input int a, input int b);
    int n = 0;
    while (a != 0 && b != 0) begin
      if (a < b) b = b - a; else a = a - b;
      n++;
    end
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int a, input int b);
    @(negedge clk);
    load_i = 1'b1; x_i = a[N-1:0]; y_i = b[N-1:0];
    @(posedge clk);
    @(negedge clk);
    check("R2 done low after load", done_o, 0);
    load_i = 1'b0;
  endtask

  // Waits for done; returns number of edges since load fell.
  task automatic wait_done(output int edges);
    edges = 0;
    forever begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (done_o) break;
      if (edges > 1000) begin hung = 1; break; end
    end
  endtask

  task automatic run(input string tag, input int a, input int b);
    int edges;
    do_load(a, b);
    wait_done(edges);
    check({tag, " R9 gcd"}, z_o, ref_gcd(a, b));
    check({tag, " R9 latency"}, edges, ref_steps(a, b) + 1);
    repeat (3) @(negedge clk);
    check({tag, " R8 done held"}, done_o, 1);
    check({tag, " R8 z held"}, z_o, ref_gcd(a, b));
  endtask

  initial begin
    int edges, dummy;
    dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1 done after reset", done_o, 0);
    check("R1 z after reset", z_o, 0);
    rst = 1'b0;

    run("R6 x zero", 0, 37);
    run("R6 y zero", 91, 0);
    run("R6 both zero", 0, 0);
    run("R7 equal", 44, 44);
    run("R3 x greater", 252, 105);
    run("R3 x less", 18, 240);
    run("R4 worst", 255, 1);
    run("R4 coprime", 1, 255);
    run("R5 max", 255, 255);

    // R8: load clears done on the next edge
    @(negedge clk);
    load_i = 1'b1; x_i = 8'd9; y_i = 8'd6;
    @(posedge clk);
    @(negedge clk);
    check("R8 load clears done", done_o, 0);
    load_i = 1'b0;
    wait_done(edges);
    check("R9 after reload", z_o, 3);

    // Load collides with termination edge: 3,3 would finish at edge 2
    do_load(3, 3);
    @(posedge clk);
    @(negedge clk);
    check("R7 not done after one step", done_o, 0);
    load_i = 1'b1; x_i = 8'd20; y_i = 8'd12;
    @(posedge clk);
    @(negedge clk);
    check("R2 load wins over finish", done_o, 0);
    load_i = 1'b0;
    wait_done(edges);
    check("R9 collide gcd", z_o, 4);
    check("R9 collide latency", edges, ref_steps(20, 12) + 1);

    for (int k = 0; k < 60 && !hung; k++) begin
      int a, b;
      a = $urandom_range(255, 0);
      b = $urandom_range(255, 0);
      if (k % 7 == 0) b = a * ($urandom_range(3, 1)) % 256;
      run("R9 random", a, b);
    end

    if (hung) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    checks++; fails++;
    $display("FAIL R9 global watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule